// File: doc/BRIEF.md
# Pipeline Hazard and Operand Forwarding Control

This block holds the interlock and bypass decisions for a five-stage in-order integer pipeline. It looks at the register numbers and the write and load bits held in the fetch/decode, decode/execute, execute/memory and memory/writeback pipeline registers. It is purely combinational. From these it drives three stall strobes: the program counter write enable, the fetch/decode register write enable, and a bubble select that zeroes the control bits entering the execute stage. It also drives two 2-bit operand-select codes, one for each ALU input multiplexer.

A static mode input chooses between two pipeline builds. With full forwarding, results are bypassed to the ALU, and only a load followed at once by a consumer of its result has to wait. Without forwarding, every operand comes from the register file. In that build, the decoding instruction waits while any producer of one of its sources is still in execute or memory. The register file is assumed to write in the first half of a cycle and read in the second, so a producer in writeback never needs a stall.

Top module: `hazardForwardCtl`

## Requirements
- R1: The fetch/decode write enable `ifIdWrite` always equals `pcWrite`.
- R2: The bubble select `idExBubble` is always the inverse of `pcWrite`.
- R3: Each operand select uses a fixed code: 0 selects the register file, 1 selects the result of the instruction one ahead (held in execute/memory), and 2 selects the result of the instruction two ahead (held in memory/writeback). Code 3 never appears.
- R4: With `fwdMode`=1, a non-load instruction in execute never causes a stall, whatever its destination.
- R5: With `fwdMode`=1, a writing load in execute whose `exRt` equals `idRs` or `idRt` drops `pcWrite` to 0. The same load one stage later, in memory, causes no stall, so the wait lasts exactly one cycle.
- R6: With `fwdMode`=0, `pcWrite` is 0 when either decode source matches the destination of the writing instruction in execute, or the destination `memDst` of the writing instruction in memory. A match only with the writeback stage does not stall.
- R7: With `fwdMode`=0, the execute-stage destination is `exRt` when `exMemRead`=1 and `exRd` otherwise.
- R8: Register number 0 never counts as a match for a stall or for a forward. A stage whose write bit is 0 never counts as a match.
- R9: When the instructions one ahead and two ahead both write the register an operand reads, that operand's select is 1.
- R10: With `fwdMode`=0, both operand selects are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fwdMode | input | 1 | 1 = full-forwarding build, 0 = no forwarding |
| idRs | input | REG_W | First source register of the instruction in decode |
| idRt | input | REG_W | Second source register of the instruction in decode |
| exRs | input | REG_W | First source register of the instruction in execute |
| exRt | input | REG_W | rt field of the instruction in execute (second source, load destination) |
| exRd | input | REG_W | rd field of the instruction in execute |
| exMemRead | input | 1 | Instruction in execute is a load |
| exRegWrite | input | 1 | Instruction in execute writes a register |
| memRegWrite | input | 1 | Instruction in memory writes a register |
| memDst | input | REG_W | Selected destination held in execute/memory |
| wbRegWrite | input | 1 | Instruction in writeback writes a register |
| wbDst | input | REG_W | Destination held in memory/writeback |
| pcWrite | output | 1 | Program counter write enable |
| ifIdWrite | output | 1 | Fetch/decode register write enable |
| idExBubble | output | 1 | Zero the control bits entering execute |
| aluSelA | output | 2 | Operand select for ALU input A |
| aluSelB | output | 2 | Operand select for ALU input B |

## Verification
The sweeps go after register 0 as a destination. A design that let it match would stall, or forward a stale value, on every instruction that writes nothing useful. They cover loads against non-loads in execute under both modes. Taking `exRd` as the destination of a load, or stalling behind an ALU producer when forwarding is on, shows up as a wrong `pcWrite` on specific register patterns. A load sitting in memory is tried in both modes: it must stall only in the no-forwarding build. Double hits on one source are tried as well, where a design that preferred the older value would return code 2 instead of 1.

// File: rtl/hazPkg.sv
package hazPkg;

  // Stall and bypass strobes sent from the interlock logic to the select logic
  typedef struct packed {
    logic pcWrite;
    logic ifIdWrite;
    logic idExBubble;
    logic fwdEn;
  } stallCtlT;

  // Operand-select codes; the order of the values is fixed by the mux wiring
  typedef enum logic [1:0] {
    SEL_REGFILE = 2'd0,
    SEL_ONE_AHEAD = 2'd1,
    SEL_TWO_AHEAD = 2'd2
  } opSelT;

  localparam int NUM_SRC = 2;

endpackage

// File: rtl/hazardCtl.sv
module hazardCtl
  import hazPkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             fwdMode,
  input  logic [REG_W-1:0] idRs,
  input  logic [REG_W-1:0] idRt,
  input  logic             exMemRead,
  input  logic             exRegWrite,
  input  logic [REG_W-1:0] exRt,
  input  logic [REG_W-1:0] exRd,
  input  logic             memRegWrite,
  input  logic [REG_W-1:0] memDst,
  output stallCtlT         ctl
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic [REG_W-1:0] exDst;
  logic [NUM_SRC-1:0] loadHit;
  logic [NUM_SRC-1:0] exHit;
  logic [NUM_SRC-1:0] memHit;
  logic [REG_W-1:0] srcReg [NUM_SRC];
  logic stallNow;

  assign srcReg[0] = idRs;
  assign srcReg[1] = idRt;

  // Loads write rt; register-type instructions write rd
  assign exDst = exMemRead ? exRt : exRd;

  genvar s;
  generate
    for (s = 0; s < NUM_SRC; s++) begin : g_src
      logic srcLive;
      assign srcLive   = (srcReg[s] != ZERO_REG);
      assign loadHit[s] = srcLive && exMemRead && exRegWrite && (exRt == srcReg[s]);
      assign exHit[s]   = srcLive && exRegWrite && (exDst == srcReg[s]);
      assign memHit[s]  = srcLive && memRegWrite && (memDst == srcReg[s]);
    end
  endgenerate

  always_comb begin
    if (fwdMode) stallNow = |loadHit;
    else         stallNow = |(exHit | memHit);
    ctl.pcWrite    = !stallNow;
    ctl.ifIdWrite  = !stallNow;
    ctl.idExBubble = stallNow;
    ctl.fwdEn      = fwdMode;
  end

  // Checks against the port-level stall rules
  always_comb begin
    a_r4_alu_no_stall: assert (!(fwdMode && !exMemRead) || ctl.pcWrite)
      else $error("non-load in execute stalled with forwarding on");
    a_r8_zero_src_no_stall: assert (!(idRs == ZERO_REG && idRt == ZERO_REG) || ctl.pcWrite)
      else $error("register 0 sources caused a stall");
    a_r8_no_writers_no_stall: assert (exRegWrite || memRegWrite || ctl.pcWrite)
      else $error("stall with no writing producer");
    a_r5_mem_load_free: assert (!(fwdMode && !exRegWrite) || ctl.pcWrite)
      else $error("stall from memory stage with forwarding on");
  end

endmodule

// File: rtl/forwardSel.sv
module forwardSel
  import hazPkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             fwdEn,
  input  logic [REG_W-1:0] exRs,
  input  logic [REG_W-1:0] exRt,
  input  logic             memRegWrite,
  input  logic [REG_W-1:0] memDst,
  input  logic             wbRegWrite,
  input  logic [REG_W-1:0] wbDst,
  output logic [1:0]       selA,
  output logic [1:0]       selB
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic [REG_W-1:0] opReg [NUM_SRC];
  opSelT opSel [NUM_SRC];

  assign opReg[0] = exRs;
  assign opReg[1] = exRt;

  genvar k;
  generate
    for (k = 0; k < NUM_SRC; k++) begin : g_op
      logic hitNear;
      logic hitFar;
      assign hitNear = fwdEn && memRegWrite && (memDst != ZERO_REG) && (memDst == opReg[k]);
      assign hitFar  = fwdEn && wbRegWrite && (wbDst != ZERO_REG) && (wbDst == opReg[k]);

      // The nearer producer holds the newer value and wins
      always_comb begin
        if (hitNear)     opSel[k] = SEL_ONE_AHEAD;
        else if (hitFar) opSel[k] = SEL_TWO_AHEAD;
        else             opSel[k] = SEL_REGFILE;
      end

      always_comb begin
        a_r3_code_range: assert (opSel[k] != 2'd3)
          else $error("illegal select code");
        a_r10_off_means_regfile: assert (fwdEn || opSel[k] == SEL_REGFILE)
          else $error("bypass selected with forwarding off");
        a_r9_newer_wins: assert (!(fwdEn && memRegWrite && memDst == opReg[k] &&
                                   opReg[k] != ZERO_REG) || opSel[k] == SEL_ONE_AHEAD)
          else $error("older producer chosen over newer");
      end
    end
  endgenerate

  assign selA = opSel[0];
  assign selB = opSel[1];

endmodule

// File: rtl/hazardForwardCtl.sv
module hazardForwardCtl
  import hazPkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             fwdMode,
  input  logic [REG_W-1:0] idRs,
  input  logic [REG_W-1:0] idRt,
  input  logic [REG_W-1:0] exRs,
  input  logic [REG_W-1:0] exRt,
  input  logic [REG_W-1:0] exRd,
  input  logic             exMemRead,
  input  logic             exRegWrite,
  input  logic             memRegWrite,
  input  logic [REG_W-1:0] memDst,
  input  logic             wbRegWrite,
  input  logic [REG_W-1:0] wbDst,
  output logic             pcWrite,
  output logic             ifIdWrite,
  output logic             idExBubble,
  output logic [1:0]       aluSelA,
  output logic [1:0]       aluSelB
);

  stallCtlT ctl;

  hazardCtl #(.REG_W(REG_W)) u_hazard (
    .fwdMode     (fwdMode),
    .idRs        (idRs),
    .idRt        (idRt),
    .exMemRead   (exMemRead),
    .exRegWrite  (exRegWrite),
    .exRt        (exRt),
    .exRd        (exRd),
    .memRegWrite (memRegWrite),
    .memDst      (memDst),
    .ctl         (ctl)
  );

  forwardSel #(.REG_W(REG_W)) u_fwd (
    .fwdEn       (ctl.fwdEn),
    .exRs        (exRs),
    .exRt        (exRt),
    .memRegWrite (memRegWrite),
    .memDst      (memDst),
    .wbRegWrite  (wbRegWrite),
    .wbDst       (wbDst),
    .selA        (aluSelA),
    .selB        (aluSelB)
  );

  assign pcWrite    = ctl.pcWrite;
  assign ifIdWrite  = ctl.ifIdWrite;
  assign idExBubble = ctl.idExBubble;

endmodule

// File: tb/hazardForwardCtl_test.sv
module hazardForwardCtl_test;

  localparam int REG_W = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic             fwdMode, exMemRead, exRegWrite, memRegWrite, wbRegWrite;
  logic [REG_W-1:0] idRs, idRt, exRs, exRt, exRd, memDst, wbDst;
  logic             pcWrite, ifIdWrite, idExBubble;
  logic [1:0]       aluSelA, aluSelB;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  hazardForwardCtl #(.REG_W(REG_W)) uut (
    .fwdMode(fwdMode), .idRs(idRs), .idRt(idRt), .exRs(exRs), .exRt(exRt),
    .exRd(exRd), .exMemRead(exMemRead), .exRegWrite(exRegWrite),
    .memRegWrite(memRegWrite), .memDst(memDst), .wbRegWrite(wbRegWrite),
    .wbDst(wbDst), .pcWrite(pcWrite), .ifIdWrite(ifIdWrite),
    .idExBubble(idExBubble), .aluSelA(aluSelA), .aluSelB(aluSelB)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (mode=%0d id=%0d,%0d ex=%0d/%0d/%0d ld=%0d w=%0d mem=%0d/%0d wb=%0d/%0d)",
               req, act, exp, fwdMode, idRs, idRt, exRs, exRt, exRd, exMemRead,
               exRegWrite, memRegWrite, memDst, wbRegWrite, wbDst);
    end
  endtask

  function automatic bit hit(input bit wr, input logic [REG_W-1:0] dst,
                             input logic [REG_W-1:0] src);
    return wr && (dst != 0) && (dst == src);
  endfunction

  function automatic int expSel(input logic [REG_W-1:0] src);
    if (!fwdMode) return 0;                       // R10
    if (hit(memRegWrite, memDst, src)) return 1;  // R9: newer first
    if (hit(wbRegWrite, wbDst, src)) return 2;
    return 0;
  endfunction

  function automatic int expPc();
    logic [REG_W-1:0] eDst;
    bit st;
    eDst = exMemRead ? exRt : exRd;  // R7
    if (fwdMode)
      st = exMemRead && (hit(exRegWrite, exRt, idRs) || hit(exRegWrite, exRt, idRt));
    else
      st = hit(exRegWrite, eDst, idRs) || hit(exRegWrite, eDst, idRt) ||
           hit(memRegWrite, memDst, idRs) || hit(memRegWrite, memDst, idRt);
    return st ? 0 : 1;
  endfunction

  task automatic checkAll();
    int ep;
    ep = expPc();
    if (!fwdMode) check("R6", pcWrite, ep);
    else if (exMemRead) check("R5", pcWrite, ep);
    else check("R4", pcWrite, ep);
    check("R1", ifIdWrite, pcWrite);
    check("R2", idExBubble, !pcWrite);
    if (pcWrite) begin
      check(fwdMode ? "R3" : "R10", aluSelA, expSel(exRs));
      check(fwdMode ? "R9" : "R10", aluSelB, expSel(exRt));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    fwdMode = 1; idRs = 0; idRt = 0; exRs = 0; exRt = 0; exRd = 0;
    exMemRead = 0; exRegWrite = 0; memRegWrite = 0; memDst = 0;
    wbRegWrite = 0; wbDst = 0;
    @(negedge clk); #5;
    // Idle state: no stall, register file operands (R8)
    check("R8", pcWrite, 1);
    check("R8", aluSelA, 0);

    // Stall sweep: decode sources against execute and memory producers
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          for (int ld = 0; ld < 2; ld++)
            for (int ew = 0; ew < 2; ew++)
              for (int t = 0; t < 4; t++)
                for (int d = 0; d < 4; d++)
                  for (int mw = 0; mw < 2; mw++)
                    for (int md = 0; md < 4; md++) begin
                      @(negedge clk);
                      fwdMode = m[0]; idRs = a[REG_W-1:0]; idRt = b[REG_W-1:0];
                      exMemRead = ld[0]; exRegWrite = ew[0];
                      exRt = t[REG_W-1:0]; exRd = d[REG_W-1:0];
                      memRegWrite = mw[0]; memDst = md[REG_W-1:0];
                      exRs = 0; wbRegWrite = 0; wbDst = 0;
                      #5 checkAll();
                    end

    // Forward sweep: execute operands against memory and writeback producers
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          for (int mw = 0; mw < 2; mw++)
            for (int md = 0; md < 4; md++)
              for (int ww = 0; ww < 2; ww++)
                for (int wd = 0; wd < 4; wd++) begin
                  @(negedge clk);
                  fwdMode = m[0]; exRs = a[REG_W-1:0]; exRt = b[REG_W-1:0];
                  exRd = 0; exMemRead = 0; exRegWrite = 0; idRs = 0; idRt = 0;
                  memRegWrite = mw[0]; memDst = md[REG_W-1:0];
                  wbRegWrite = ww[0]; wbDst = wd[REG_W-1:0];
                  #5 checkAll();
                end

    // Directed: a load stalls one cycle, then the same load in memory does not (R5)
    @(negedge clk);
    fwdMode = 1; idRs = 5'd9; idRt = 5'd1; exMemRead = 1; exRegWrite = 1;
    exRt = 5'd9; exRd = 5'd0; memRegWrite = 0; memDst = 0; wbRegWrite = 0;
    #5 check("R5", pcWrite, 0);
    @(negedge clk);
    exMemRead = 0; exRegWrite = 0; memRegWrite = 1; memDst = 5'd9;
    #5 check("R5", pcWrite, 1);
    // Load must use rt, not rd, as its destination (R7)
    @(negedge clk);
    fwdMode = 0; memRegWrite = 0; exMemRead = 1; exRegWrite = 1;
    exRt = 5'd20; exRd = 5'd9;
    #5 check("R7", pcWrite, 1);
    // High register numbers, double hit on operand B (R9)
    @(negedge clk);
    fwdMode = 1; exMemRead = 0; exRegWrite = 0; exRs = 5'd31; exRt = 5'd17;
    memRegWrite = 1; memDst = 5'd17; wbRegWrite = 1; wbDst = 5'd17;
    #5 check("R9", aluSelB, 1);
    check("R3", aluSelA, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule